// File: doc/BRIEF.md
# Pipeline Hazard and Branch Control

This block is the hazard and steering logic of a five-stage in-order RISC pipeline with fetch, decode, execute, memory and write-back stages. It reads the register numbers and control bits held in the decode stage and in the three later pipeline registers. From these it produces four kinds of output:

- operand selects for the execute-stage multiplexers, so that a result still in flight is used instead of the stale register-file copy;
- a stall that freezes the PC and the decode register while a bubble enters execute;
- a taken indication for branches and jumps, resolved in decode;
- a PC source select.

Control bits travel down the pipeline beside the data. Each bit is consumed in the stage that needs it, and the write-enable for the register file travels the farthest. The register file writes in the first half of a cycle and is read in the second half, so a register being written back is already visible to decode and is never a hazard.

Branches compare two registers for equality or inequality in decode and take effect at once. Exactly one instruction after a branch or jump has been fetched, and it always executes as the delay slot, so no flush path exists. A branch whose operand comes from the execute stage, or from a load still in the memory stage, waits in decode until the value can reach the comparator. A non-load result in the memory stage is bypassed straight to the comparator. All decisions are combinational from the current pipeline register contents. The clock and reset only time the built-in protocol checks.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each execute operand select is 2'b01 (EX/MEM result) when the EX/MEM stage writes that operand's register, otherwise 2'b10 (MEM/WB result) when the MEM/WB stage writes it, otherwise 2'b00 (register file); EX/MEM wins when both match, and 2'b11 never appears.
- R2: Register 0 is never forwarded and never causes a stall, in the execute selects, the load-use check and the branch checks alike.
- R3: A register being written by the MEM/WB stage and read in decode in the same cycle causes no stall.
- R4: When the execute stage holds a load (load flag and write flag set) whose destination equals a decode source that is marked as used, pc_hold, ifid_hold and idex_bubble are all 1 in that cycle; an unused source field never stalls.
- R5: A non-load producer in the execute stage never stalls a non-branch consumer in decode; all three stall outputs stay 0.
- R6: id_br_op encodes 2'b00 no branch, 2'b01 branch if equal, 2'b10 branch if not equal, 2'b11 jump. pc_src encodes 2'b00 sequential, 2'b01 branch target, 2'b10 jump target. branch_taken is 1 exactly when pc_src is not 2'b00. Branches always read both register fields, whatever their use flags.
- R7: The branch comparator uses mem_alu_result in place of a decode read value when the memory stage writes that source register and is not a load.
- R8: A branch stalls (all three stall outputs 1) when the execute stage writes either branch source, or when a load in the memory stage writes either branch source. While stalled, pc_src is 2'b00 and branch_taken is 0.
- R9: A jump always selects the jump target and never stalls, even with its register fields and use flags matching a pending load or producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the built-in checks |
| rst_n | input | 1 | Active-low reset for the built-in checks |
| id_rs | input | REG_W | First source register of the decode instruction |
| id_rt | input | REG_W | Second source register of the decode instruction |
| id_uses_rs | input | 1 | Decode instruction reads id_rs |
| id_uses_rt | input | 1 | Decode instruction reads id_rt |
| id_br_op | input | 2 | Branch/jump opcode class in decode |
| id_rs_val | input | XLEN | Register-file value read for id_rs |
| id_rt_val | input | XLEN | Register-file value read for id_rt |
| ex_rs | input | REG_W | First source register held in ID/EX |
| ex_rt | input | REG_W | Second source register held in ID/EX |
| ex_rd | input | REG_W | Destination register held in ID/EX |
| ex_reg_write | input | 1 | ID/EX instruction writes a register |
| ex_mem_read | input | 1 | ID/EX instruction is a load |
| mem_rd | input | REG_W | Destination register held in EX/MEM |
| mem_reg_write | input | 1 | EX/MEM instruction writes a register |
| mem_mem_read | input | 1 | EX/MEM instruction is a load |
| mem_alu_result | input | XLEN | ALU result held in EX/MEM |
| wb_rd | input | REG_W | Destination register held in MEM/WB |
| wb_reg_write | input | 1 | MEM/WB instruction writes a register |
| fwd_a_sel | output | 2 | Execute operand A source select |
| fwd_b_sel | output | 2 | Execute operand B source select |
| pc_hold | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold | output | 1 | Keep the IF/ID register unchanged this cycle |
| idex_bubble | output | 1 | Clear ID/EX control bits to a bubble |
| branch_taken | output | 1 | Control transfer happens after the delay slot |
| pc_src | output | 2 | Next-PC source select |

## Verification
A branch in decode can face a load-type hazard while its other operand is being bypassed from the memory stage. A jump can sit in decode while a load in execute writes a register named in its fields. The branch sweep provokes both by crossing every opcode with every pairing of source, execute and memory destinations over registers 0 to 3. Across that sweep the write and load flags take every value, and operand values are chosen so that the equality outcome flips only if the bypass is taken. Each vector is judged by an arithmetic model in the bench: stall before redirect, bypass before compare, and a jump never held.

// File: rtl/hz_ctrl_pkg.sv
`timescale 1ns/1ps
package hz_ctrl_pkg;

   typedef enum logic [1:0] {
      FWD_RF    = 2'b00,
      FWD_EXMEM = 2'b01,
      FWD_MEMWB = 2'b10
   } fwd_sel_e;

   typedef enum logic [1:0] {
      BR_NONE = 2'b00,
      BR_EQ   = 2'b01,
      BR_NE   = 2'b10,
      BR_JUMP = 2'b11
   } br_op_e;

   typedef enum logic [1:0] {
      PC_SEQ    = 2'b00,
      PC_BRANCH = 2'b01,
      PC_JUMP   = 2'b10
   } pc_src_e;

   localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/hz_src_match.sv
`timescale 1ns/1ps
module hz_src_match #(
   parameter int unsigned REG_W         = 5,
   parameter bit          ZERO_IS_CONST = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   input  logic             wr_en,
   output logic             hit
);

   generate
      if (ZERO_IS_CONST) begin : g_zero_const
         assign hit = wr_en && (src == dst) && (dst != '0);
      end else begin : g_zero_plain
         assign hit = wr_en && (src == dst);
      end
   endgenerate

endmodule

// File: rtl/hz_fwd_unit.sv
`timescale 1ns/1ps
module hz_fwd_unit
   import hz_ctrl_pkg::*;
#(
   parameter int unsigned REG_W         = 5,
   parameter bit          ZERO_IS_CONST = 1'b1
) (
   input  logic [NUM_SRC-1:0][REG_W-1:0] ex_src,
   input  logic [REG_W-1:0]              mem_rd,
   input  logic                          mem_reg_write,
   input  logic [REG_W-1:0]              wb_rd,
   input  logic                          wb_reg_write,
   output logic [NUM_SRC-1:0][1:0]       sel
);

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         logic hit_mem;
         logic hit_wb;

         hz_src_match #(.REG_W(REG_W), .ZERO_IS_CONST(ZERO_IS_CONST)) u_mem (
            .src   (ex_src[s]),
            .dst   (mem_rd),
            .wr_en (mem_reg_write),
            .hit   (hit_mem)
         );

         hz_src_match #(.REG_W(REG_W), .ZERO_IS_CONST(ZERO_IS_CONST)) u_wb (
            .src   (ex_src[s]),
            .dst   (wb_rd),
            .wr_en (wb_reg_write),
            .hit   (hit_wb)
         );

         always_comb begin
            if (hit_mem)     sel[s] = FWD_EXMEM;
            else if (hit_wb) sel[s] = FWD_MEMWB;
            else             sel[s] = FWD_RF;
         end
      end
   endgenerate

endmodule

// File: rtl/hz_stall_unit.sv
`timescale 1ns/1ps
module hz_stall_unit
   import hz_ctrl_pkg::*;
#(
   parameter int unsigned REG_W         = 5,
   parameter bit          ZERO_IS_CONST = 1'b1
) (
   input  logic [NUM_SRC-1:0][REG_W-1:0] id_src,
   input  logic [NUM_SRC-1:0]            id_uses,
   input  logic [1:0]                    id_br_op,
   input  logic [REG_W-1:0]              ex_rd,
   input  logic                          ex_reg_write,
   input  logic                          ex_mem_read,
   input  logic [REG_W-1:0]              mem_rd,
   input  logic                          mem_reg_write,
   input  logic                          mem_mem_read,
   output logic                          stall
);

   logic                is_branch;
   logic                is_jump;
   logic [NUM_SRC-1:0]  eff_uses;
   logic [NUM_SRC-1:0]  hit_ex;
   logic [NUM_SRC-1:0]  hit_mem;
   logic                load_use;
   logic                br_wait;

   assign is_branch = (id_br_op == BR_EQ) || (id_br_op == BR_NE);
   assign is_jump   = (id_br_op == BR_JUMP);

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         assign eff_uses[s] = is_branch ? 1'b1 : (is_jump ? 1'b0 : id_uses[s]);

         hz_src_match #(.REG_W(REG_W), .ZERO_IS_CONST(ZERO_IS_CONST)) u_ex (
            .src   (id_src[s]),
            .dst   (ex_rd),
            .wr_en (ex_reg_write),
            .hit   (hit_ex[s])
         );

         hz_src_match #(.REG_W(REG_W), .ZERO_IS_CONST(ZERO_IS_CONST)) u_mem (
            .src   (id_src[s]),
            .dst   (mem_rd),
            .wr_en (mem_reg_write),
            .hit   (hit_mem[s])
         );
      end
   endgenerate

   assign load_use = ex_mem_read && |(hit_ex & eff_uses);
   assign br_wait  = is_branch && (|hit_ex || (mem_mem_read && |hit_mem));
   assign stall    = load_use || br_wait;

endmodule

// File: rtl/hz_branch_unit.sv
`timescale 1ns/1ps
module hz_branch_unit
   import hz_ctrl_pkg::*;
#(
   parameter int unsigned REG_W         = 5,
   parameter int unsigned XLEN          = 32,
   parameter bit          ZERO_IS_CONST = 1'b1
) (
   input  logic [NUM_SRC-1:0][REG_W-1:0] id_src,
   input  logic [NUM_SRC-1:0][XLEN-1:0]  id_val,
   input  logic [1:0]                    id_br_op,
   input  logic [REG_W-1:0]              mem_rd,
   input  logic                          mem_reg_write,
   input  logic                          mem_mem_read,
   input  logic [XLEN-1:0]               mem_alu_result,
   input  logic                          stall,
   output logic [1:0]                    pc_src,
   output logic                          taken
);

   logic [NUM_SRC-1:0][XLEN-1:0] cmp_val;
   logic                          ops_equal;

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         logic bypass;

         hz_src_match #(.REG_W(REG_W), .ZERO_IS_CONST(ZERO_IS_CONST)) u_byp (
            .src   (id_src[s]),
            .dst   (mem_rd),
            .wr_en (mem_reg_write && !mem_mem_read),
            .hit   (bypass)
         );

         assign cmp_val[s] = bypass ? mem_alu_result : id_val[s];
      end
   endgenerate

   assign ops_equal = (cmp_val[0] == cmp_val[1]);

   always_comb begin
      pc_src = PC_SEQ;
      unique case (id_br_op)
         BR_JUMP: pc_src = PC_JUMP;
         BR_EQ:   if (!stall && ops_equal)  pc_src = PC_BRANCH;
         BR_NE:   if (!stall && !ops_equal) pc_src = PC_BRANCH;
         default: pc_src = PC_SEQ;
      endcase
   end

   assign taken = (pc_src != PC_SEQ);

endmodule

// File: rtl/pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl
   import hz_ctrl_pkg::*;
#(
   parameter int unsigned REG_W         = 5,
   parameter int unsigned XLEN          = 32,
   parameter bit          ZERO_IS_CONST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] id_rs,
   input  logic [REG_W-1:0] id_rt,
   input  logic             id_uses_rs,
   input  logic             id_uses_rt,
   input  logic [1:0]       id_br_op,
   input  logic [XLEN-1:0]  id_rs_val,
   input  logic [XLEN-1:0]  id_rt_val,
   input  logic [REG_W-1:0] ex_rs,
   input  logic [REG_W-1:0] ex_rt,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             ex_reg_write,
   input  logic             ex_mem_read,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_reg_write,
   input  logic             mem_mem_read,
   input  logic [XLEN-1:0]  mem_alu_result,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_reg_write,
   output logic [1:0]       fwd_a_sel,
   output logic [1:0]       fwd_b_sel,
   output logic             pc_hold,
   output logic             ifid_hold,
   output logic             idex_bubble,
   output logic             branch_taken,
   output logic [1:0]       pc_src
);

   localparam int unsigned MAX_REG_W = 8;

   generate
      if (REG_W < 1 || REG_W > MAX_REG_W) begin : g_bad_reg_w
         $error("pipe_hazard_ctrl: REG_W out of supported range");
      end
      if (XLEN < 1) begin : g_bad_xlen
         $error("pipe_hazard_ctrl: XLEN must be positive");
      end
   endgenerate

   logic [NUM_SRC-1:0][REG_W-1:0] ex_src;
   logic [NUM_SRC-1:0][REG_W-1:0] id_src;
   logic [NUM_SRC-1:0][XLEN-1:0]  id_val;
   logic [NUM_SRC-1:0]            id_uses;
   logic [NUM_SRC-1:0][1:0]       sel;
   logic                          stall;

   assign ex_src  = {ex_rt, ex_rs};
   assign id_src  = {id_rt, id_rs};
   assign id_val  = {id_rt_val, id_rs_val};
   assign id_uses = {id_uses_rt, id_uses_rs};

   hz_fwd_unit #(.REG_W(REG_W), .ZERO_IS_CONST(ZERO_IS_CONST)) u_fwd (
      .ex_src        (ex_src),
      .mem_rd        (mem_rd),
      .mem_reg_write (mem_reg_write),
      .wb_rd         (wb_rd),
      .wb_reg_write  (wb_reg_write),
      .sel           (sel)
   );

   hz_stall_unit #(.REG_W(REG_W), .ZERO_IS_CONST(ZERO_IS_CONST)) u_stall (
      .id_src        (id_src),
      .id_uses       (id_uses),
      .id_br_op      (id_br_op),
      .ex_rd         (ex_rd),
      .ex_reg_write  (ex_reg_write),
      .ex_mem_read   (ex_mem_read),
      .mem_rd        (mem_rd),
      .mem_reg_write (mem_reg_write),
      .mem_mem_read  (mem_mem_read),
      .stall         (stall)
   );

   hz_branch_unit #(.REG_W(REG_W), .XLEN(XLEN), .ZERO_IS_CONST(ZERO_IS_CONST)) u_br (
      .id_src         (id_src),
      .id_val         (id_val),
      .id_br_op       (id_br_op),
      .mem_rd         (mem_rd),
      .mem_reg_write  (mem_reg_write),
      .mem_mem_read   (mem_mem_read),
      .mem_alu_result (mem_alu_result),
      .stall          (stall),
      .pc_src         (pc_src),
      .taken          (branch_taken)
   );

   assign fwd_a_sel   = sel[0];
   assign fwd_b_sel   = sel[1];
   assign pc_hold     = stall;
   assign ifid_hold   = stall;
   assign idex_bubble = stall;

endmodule

// File: rtl/hz_ctrl_chk.sv
`timescale 1ns/1ps
module hz_ctrl_chk #(
   parameter int unsigned REG_W         = 5,
   parameter bit          ZERO_IS_CONST = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] id_rs,
   input logic [REG_W-1:0] id_rt,
   input logic [1:0]       id_br_op,
   input logic [REG_W-1:0] ex_rs,
   input logic [REG_W-1:0] ex_rt,
   input logic             ex_reg_write,
   input logic [REG_W-1:0] mem_rd,
   input logic             mem_reg_write,
   input logic             mem_mem_read,
   input logic [1:0]       fwd_a_sel,
   input logic [1:0]       fwd_b_sel,
   input logic             pc_hold,
   input logic             branch_taken,
   input logic [1:0]       pc_src
);

   assert_sel_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a_sel != 2'b11) && (fwd_b_sel != 2'b11));

   generate
      if (ZERO_IS_CONST) begin : g_zero
         assert_zero_unforwarded_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ((ex_rs == '0) |-> (fwd_a_sel == 2'b00)) and
            ((ex_rt == '0) |-> (fwd_b_sel == 2'b00)));
      end
   endgenerate

   assert_no_stall_without_producer_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ex_reg_write && !mem_reg_write) |-> !pc_hold);

   assert_hold_blocks_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |-> ((pc_src == 2'b00) && !branch_taken));

   assert_mem_load_branch_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (((id_br_op == 2'b01) || (id_br_op == 2'b10)) && mem_mem_read && mem_reg_write &&
       (mem_rd != '0) && ((mem_rd == id_rs) || (mem_rd == id_rt))) |-> pc_hold);

   assert_jump_never_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (id_br_op == 2'b11) |-> (!pc_hold && (pc_src == 2'b10) && branch_taken));

   assert_taken_matches_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      branch_taken == (pc_src != 2'b00));

endmodule

bind pipe_hazard_ctrl hz_ctrl_chk #(.REG_W(REG_W), .ZERO_IS_CONST(ZERO_IS_CONST)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .id_rs        (id_rs),
   .id_rt        (id_rt),
   .id_br_op     (id_br_op),
   .ex_rs        (ex_rs),
   .ex_rt        (ex_rt),
   .ex_reg_write (ex_reg_write),
   .mem_rd       (mem_rd),
   .mem_reg_write(mem_reg_write),
   .mem_mem_read (mem_mem_read),
   .fwd_a_sel    (fwd_a_sel),
   .fwd_b_sel    (fwd_b_sel),
   .pc_hold      (pc_hold),
   .branch_taken (branch_taken),
   .pc_src       (pc_src)
);

// File: tb/pipe_hazard_ctrl_tb.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_tb;

   localparam int RW = 5;
   localparam int XW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [RW-1:0] id_rs = '0, id_rt = '0;
   logic          id_uses_rs = 1'b0, id_uses_rt = 1'b0;
   logic [1:0]    id_br_op = 2'b00;
   logic [XW-1:0] id_rs_val = '0, id_rt_val = '0;
   logic [RW-1:0] ex_rs = '0, ex_rt = '0, ex_rd = '0;
   logic          ex_reg_write = 1'b0, ex_mem_read = 1'b0;
   logic [RW-1:0] mem_rd = '0;
   logic          mem_reg_write = 1'b0, mem_mem_read = 1'b0;
   logic [XW-1:0] mem_alu_result = '0;
   logic [RW-1:0] wb_rd = '0;
   logic          wb_reg_write = 1'b0;
   logic [1:0]    fwd_a_sel, fwd_b_sel, pc_src;
   logic          pc_hold, ifid_hold, idex_bubble, branch_taken;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   pipe_hazard_ctrl #(.REG_W(RW), .XLEN(XW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .id_rs(id_rs), .id_rt(id_rt), .id_uses_rs(id_uses_rs), .id_uses_rt(id_uses_rt),
      .id_br_op(id_br_op), .id_rs_val(id_rs_val), .id_rt_val(id_rt_val),
      .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd),
      .ex_reg_write(ex_reg_write), .ex_mem_read(ex_mem_read),
      .mem_rd(mem_rd), .mem_reg_write(mem_reg_write), .mem_mem_read(mem_mem_read),
      .mem_alu_result(mem_alu_result),
      .wb_rd(wb_rd), .wb_reg_write(wb_reg_write),
      .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
      .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
      .branch_taken(branch_taken), .pc_src(pc_src)
   );

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic [1:0] exp_sel(input int src, input int mrd, input bit mw,
                                           input int wrd, input bit ww);
      if (src != 0 && mw && mrd == src) return 2'b01;
      if (src != 0 && ww && wrd == src) return 2'b10;
      return 2'b00;
   endfunction

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // reset state: all-quiet inputs give no forwarding, no hold, no redirect
      repeat (2) @(negedge clk);
      check("R1 reset fwd", {4'h0, fwd_a_sel, fwd_b_sel}, 8'h00);
      check("R6 reset ctl", {3'b0, pc_hold, ifid_hold, idex_bubble, pc_src}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // execute forwarding sweep, with a decode read of the write-back register
      for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
      for (int m = 0; m < 4; m++)
      for (int w = 0; w < 4; w++)
      for (int f = 0; f < 4; f++) begin
         @(negedge clk);
         ex_rs = RW'(a); ex_rt = RW'(b);
         mem_rd = RW'(m); mem_reg_write = f[0];
         wb_rd = RW'(w); wb_reg_write = f[1];
         id_rs = RW'(w); id_rt = RW'(w); id_uses_rs = 1'b1; id_uses_rt = 1'b1;
         id_br_op = 2'b00; ex_reg_write = 1'b0; ex_mem_read = 1'b0; mem_mem_read = 1'b0;
         #2;
         check((a == 0) ? "R2 fwd a zero" : "R1 fwd a", {6'b0, fwd_a_sel},
               {6'b0, exp_sel(a, m, f[0], w, f[1])});
         check((b == 0) ? "R2 fwd b zero" : "R1 fwd b", {6'b0, fwd_b_sel},
               {6'b0, exp_sel(b, m, f[0], w, f[1])});
         check("R3 wb read no stall", {5'b0, pc_hold, ifid_hold, idex_bubble}, 8'h00);
      end
      mem_reg_write = 1'b0; wb_reg_write = 1'b0;

      // load-use sweep in execute
      for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++)
      for (int d = 0; d < 4; d++)
      for (int u = 0; u < 4; u++)
      for (int c = 0; c < 4; c++) begin
         bit hz;
         @(negedge clk);
         id_rs = RW'(s); id_rt = RW'(t); id_uses_rs = u[0]; id_uses_rt = u[1];
         ex_rd = RW'(d); ex_mem_read = c[0]; ex_reg_write = c[1];
         id_br_op = 2'b00;
         hz = c[0] && c[1] && d != 0 && ((u[0] && s == d) || (u[1] && t == d));
         #2;
         check(c[0] ? ((d == 0) ? "R2 load dst zero" : "R4 load-use")
                    : "R5 alu producer no stall",
               {5'b0, pc_hold, ifid_hold, idex_bubble}, {5'b0, {3{hz}}});
         check("R6 no redirect", {6'b0, pc_src}, 8'h00);
      end
      ex_mem_read = 1'b0; ex_reg_write = 1'b0;

      // branch / jump sweep with comparator bypass and decode waits
      for (int op = 0; op < 4; op++)
      for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++)
      for (int d = 0; d < 4; d++)
      for (int m = 0; m < 4; m++)
      for (int fl = 0; fl < 8; fl++)
      for (int p = 0; p < 4; p++) begin
         bit is_br, hz, byp_a, byp_b, eq, ld_ex;
         logic [XW-1:0] va, vb, vm, ca, cb;
         logic [1:0] es;
         string tag;
         case (p)
            0: begin va = 5; vb = 5; vm = 9; end
            1: begin va = 5; vb = 7; vm = 7; end
            2: begin va = 7; vb = 5; vm = 5; end
            default: begin va = 5; vb = 7; vm = 5; end
         endcase
         @(negedge clk);
         id_br_op = 2'(op); id_rs = RW'(s); id_rt = RW'(t);
         id_uses_rs = 1'b1; id_uses_rt = 1'b1;
         id_rs_val = va; id_rt_val = vb; mem_alu_result = vm;
         ex_rd = RW'(d); ex_reg_write = fl[0];
         mem_rd = RW'(m); mem_reg_write = fl[1]; mem_mem_read = fl[2];
         ld_ex = (op == 3) && fl[0] && (p == 3);
         ex_mem_read = ld_ex;
         is_br = (op == 1) || (op == 2);
         hz = is_br && ((fl[0] && d != 0 && (d == s || d == t)) ||
                        (fl[1] && fl[2] && m != 0 && (m == s || m == t)));
         byp_a = fl[1] && !fl[2] && m != 0 && m == s;
         byp_b = fl[1] && !fl[2] && m != 0 && m == t;
         ca = byp_a ? vm : va;
         cb = byp_b ? vm : vb;
         eq = (ca == cb);
         if (hz) es = 2'b00;
         else if (op == 3) es = 2'b10;
         else if ((op == 1 && eq) || (op == 2 && !eq)) es = 2'b01;
         else es = 2'b00;
         if (op == 3) tag = "R9 jump";
         else if (hz) tag = "R8 branch wait";
         else if (is_br && (byp_a || byp_b)) tag = "R7 comparator bypass";
         else tag = "R6 branch decide";
         #2;
         check(tag, {2'b0, pc_hold, ifid_hold, idex_bubble, branch_taken, pc_src},
               {2'b0, {3{hz}}, (es != 2'b00), es});
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule